// File: doc/BRIEF.md
# Vector Byte-Lane Variable Right Shifter

This block shifts a 128-bit vector right one byte lane at a time, and each lane has its own shift amount. The first operand supplies the data and the second supplies the amounts. Each lane takes its amount from the same-numbered byte of the second operand and shifts its data byte right by that many bits. The high bits that open up are filled with the low bits of the next more significant byte of the data operand. The topmost lane has no such neighbour, so zeros fill it.

Every lane reads the data operand as it was presented, never another lane's result. Because of this the block behaves correctly when its result is written back over its data operand.

An optional output register adds one cycle of latency and holds the last result until the next valid input arrives. The reset is asserted asynchronously, active low, and is released through an internal two-stage synchronizer.

Top module: `vbyte_rshift_var`

## Requirements
- R1: The vectors are split into 16 byte lanes. Lane 0 is bits [127:120] and lane 15 is bits [7:0], so shifted-out bits travel from lane i-1 into lane i.
- R2: The amount for lane i is bits [2:0] of byte i of `op_b`. Bits [7:3] of each `op_b` byte have no effect on the result.
- R3: For i from 1 to 15, result byte i is the low 8 bits of the 16-bit value {A byte i-1, A byte i}, logically shifted right by the amount for lane i.
- R4: Lane 0 uses zero in place of a neighbour, so its result is A byte 0 shifted right with zero fill.
- R5: An amount of 0 returns the lane's A byte unchanged, whatever its neighbour holds.
- R6: Every lane is computed from the original `op_a`, with no dependence between lanes' results.
- R7: With the output register enabled (the default), `res` and `res_valid` appear one clock after `in_valid` is sampled high.
- R8: When `rst_n` is low, `res_valid` is cleared immediately. After `rst_n` rises, `res_valid` stays low for the two synchronizer cycles.
- R9: While `in_valid` is low, `res` keeps its last value and `res_valid` is low the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 128 | Data vector, lane 0 in the top byte |
| op_b | input | 128 | Per-lane shift amounts in bits [2:0] of each byte |
| res | output | 128 | Shifted vector |
| res_valid | output | 1 | `res` holds a new result |

## Verification
A wrong lane slice or a wrong neighbour choice corrupts only the affected lanes. It shows in `res` on the first valid result whose amounts are nonzero in those lanes, one cycle after the input. A wrong width for the amount field appears as soon as an `op_b` byte has its upper bits set. A lane that reads another lane's result instead of the original operand breaks the all-seven sweep at once. Errors in the valid path or the hold path show in `res_valid`, or as a changed `res`, on the cycle after `in_valid` falls.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int unsigned VRS_LANES  = 16;
  localparam int unsigned VRS_LANE_W = 8;
  localparam int unsigned VRS_AMT_W  = $clog2(VRS_LANE_W);
  localparam int unsigned VRS_DATA_W = VRS_LANES * VRS_LANE_W;
endpackage

// File: rtl/vrs_lane.sv
module vrs_lane #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  upper,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  out
);
  logic [2*W-1:0] pair;
  logic [2*W-1:0] shifted;

  always_comb begin
    pair    = {upper, cur};
    shifted = pair >> amt;
    out     = shifted[W-1:0];
  end

  // R5: a zero amount leaves the byte untouched
  always_comb begin
    if (amt == '0) assert_zero_pass_R5: assert (out == cur);
  end
endmodule

// File: rtl/vrs_ostage.sv
module vrs_ostage #(
  parameter int unsigned DW      = 128,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          q_valid
);
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  generate
    if (OUT_REG) begin : g_reg
      logic [DW-1:0] data_d, data_q;
      logic          vld_d, vld_q;

      always_comb begin
        data_d = in_valid ? d : data_q;
        vld_d  = in_valid;
      end

      always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) vld_q <= 1'b0;
        else         vld_q <= vld_d;
      end

      always_ff @(posedge clk) begin
        data_q <= data_d;
      end

      assign q       = data_q;
      assign q_valid = vld_q;

      assert_lat_R7: assert property (@(posedge clk) disable iff (!rst_ok)
        in_valid |=> (q_valid && q == $past(d)));
      assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_ok)
        !in_valid |=> (!q_valid && $stable(q)));
      assert_rst_R8: assert property (@(posedge clk)
        !rst_ok |-> !q_valid);
    end else begin : g_comb
      assign q       = d;
      assign q_valid = in_valid & rst_ok;
    end
  endgenerate
endmodule

// File: rtl/vbyte_rshift_var.sv
module vbyte_rshift_var
  import vrs_pkg::*;
#(
  parameter int unsigned LANES   = VRS_LANES,
  parameter int unsigned LANE_W  = VRS_LANE_W,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [LANES*LANE_W-1:0]   op_a,
  input  logic [LANES*LANE_W-1:0]   op_b,
  output logic [LANES*LANE_W-1:0]   res,
  output logic                      res_valid
);
  localparam int unsigned DW = LANES * LANE_W;
  localparam int unsigned AW = $clog2(LANE_W);

  logic [DW-1:0] comb_res;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned HI = DW - 1 - g * LANE_W;
      logic [LANE_W-1:0] upper;
      if (g == 0) begin : g_top
        assign upper = '0;            // R4: nothing above lane 0
      end else begin : g_mid
        assign upper = op_a[HI+LANE_W -: LANE_W];
      end
      vrs_lane #(.W(LANE_W), .AW(AW)) i_lane (
        .cur   (op_a[HI -: LANE_W]),
        .upper (upper),
        .amt   (op_b[HI-LANE_W+1 +: AW]),  // R2: low bits only
        .out   (comb_res[HI -: LANE_W])
      );
    end
  endgenerate

  // R4: lane 0 result never carries set bits above its shifted data
  always_comb begin
    assert_top_fill_R4: assert ((comb_res[DW-1 -: LANE_W] &
      ~(op_a[DW-1 -: LANE_W] >> op_b[DW-LANE_W +: AW])) == '0);
  end

  vrs_ostage #(.DW(DW), .OUT_REG(OUT_REG)) i_ostage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d        (comb_res),
    .q        (res),
    .q_valid  (res_valid)
  );
endmodule

// File: tb/test_vbyte_rshift_var.sv
module test_vbyte_rshift_var;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic [127:0] res;
  logic         res_valid;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  vbyte_rshift_var i_vbyte_rshift_var (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .res(res), .res_valid(res_valid)
  );

  always #10 clk = ~clk;

  function automatic logic [127:0] ref_model(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      int unsigned cur, up, sh, v;
      cur = a[127-8*i -: 8];
      up  = (i == 0) ? 0 : a[135-8*i -: 8];
      sh  = b[127-8*i -: 8] % 8;
      v   = ((up * 256 + cur) / (1 << sh)) % 256;
      r[127-8*i -: 8] = v[7:0];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // one vector: drive at negedge, check at the following negedge
  task automatic apply(input string req, input logic [127:0] a, input logic [127:0] b);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    chk(req, res, ref_model(a, b));
    chk({req, " valid R7"}, {127'd0, res_valid}, 128'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [127:0] a, b, keep;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R8: held in reset with valid high
    chk("R8 reset", {127'd0, res_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 sync release", {127'd0, res_valid}, 128'd0);
    @(negedge clk);
    @(negedge clk);

    // R5: all amounts zero gives a copy of A
    a = 128'h0123456789abcdef_fedcba9876543210;
    apply("R5 zero", a, '0);
    chk("R5 copy", res, a);
    // R4 R1: all amounts 7, only top bits of each neighbour kept
    apply("R4 R6 all7", a, {16{8'h07}});
    chk("R4 lane0", {120'd0, res[127:120]}, {120'd0, 8'h00});
    // R1 R3: single lane shift by 1, neighbour low bit enters
    apply("R1 R3 one", {8'h00, 8'h01, 112'd0}, {8'h00, 8'h01, 112'd0});
    chk("R1 R3 lane1", {120'd0, res[119:112]}, {120'd0, 8'h00});
    apply("R1 R3 nbr", {8'h01, 8'h00, 112'd0}, {8'h00, 8'h01, 112'd0});
    chk("R1 R3 carry", {120'd0, res[119:112]}, {120'd0, 8'h80});
    // R2: upper bits of B must not matter
    b = 128'h0102030405060700_0102030405060700;
    apply("R2 clean", a, b);
    keep = res;
    apply("R2 dirty", a, b | {16{8'hf8}});
    chk("R2 same", res, keep);
    // R6: aliasing pattern, alternating all ones and zero
    apply("R6 alt", {8{16'hff00}}, {16{8'h04}});
    chk("R6 exp", res, {8'h0f, {7{8'hf0, 8'h0f}}, 8'hf0});

    // near-exhaustive: each lane pair sees every byte value and every amount
    for (int k = 0; k < 4096; k++) begin
      for (int l = 0; l < 16; l++) begin
        a[127-8*l -: 8] = 8'((k * 7 + l * 37 + (k >> 8) * 11) & 8'hff);
        b[127-8*l -: 8] = 8'(((k + l) & 7) | (((k * 5 + l) & 31) << 3));
      end
      apply("R3 sweep", a, b);
    end

    // R9: hold when idle
    keep = res;
    in_valid = 1'b0;
    op_a = ~op_a; op_b = ~op_b;
    @(negedge clk);
    chk("R9 hold", res, keep);
    chk("R9 valid", {127'd0, res_valid}, 128'd0);
    @(negedge clk);
    chk("R9 hold2", res, keep);

    // R8: asynchronous reset mid-run
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 async", {127'd0, res_valid}, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after", {127'd0, res_valid}, 128'd0);
    @(negedge clk);
    @(negedge clk);
    apply("R7 after reset", a, b);
    finish_run();
  end
endmodule